// File: doc/BRIEF.md
# Buffered Pipeline Stage with Skid Register

This block is one stage of a streaming datapath. On its upstream side it takes words under a strobe/busy handshake, and on its downstream side it offers them under the same kind of handshake. Busy is active high on both sides. Each word gets a small combinational processing step, an increment by a parameterised amount (default one), before it reaches the output register. With downstream free and upstream strobing, one word passes through on every clock.

The busy signal sent back upstream comes from a register, so it is always one clock late. When downstream stalls, the word that upstream presented in that same clock has already been committed and cannot be withdrawn. The stage therefore takes it into a one-word skid register and raises busy on the next clock. Once downstream frees up, the skid word goes out before any fresh input. Busy drops again in the clock after the skid word has moved to the output.

Top module: `bufPipeStage`

## Requirements
- R1: A word on `upData` is taken in only on a clock where `upStb` is 1 and `upBusy` is 0. A word offered while `upBusy` is 1 never appears at the output.
- R2: A word leaves the stage on a clock where `dnStb` is 1 and `dnBusy` is 0.
- R3: With `dnBusy` held at 0 and `upStb` held at 1, a new word appears on `dnData` on every clock, one clock after it was taken in.
- R4: A word taken in while the output register holds a word that downstream is refusing is kept in the skid register and is not lost.
- R5: On the clock after such a capture, `upBusy` is 1.
- R6: When downstream frees up, the skid word is presented before any word taken in later.
- R7: `upBusy` returns to 0 on the clock after the skid word has moved into the output register.
- R8: While `dnStb` is 1 and `dnBusy` is 1, `dnStb` and `dnData` hold their values on the next clock.
- R9: Each output word equals its input word plus `STEP` (default 1), modulo 2^`WIDTH`. For example, 16'hFFFF becomes 16'h0000.
- R10: A synchronous active-high `rst` clears `dnStb`, `upBusy` and the skid register's valid flag.
- R11: Output words come out in input order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upStb | input | 1 | Upstream has a word on upData |
| upData | input | WIDTH | Upstream data word |
| upBusy | output | 1 | Registered stall indication to upstream |
| dnStb | output | 1 | Stage is offering a word on dnData |
| dnData | output | WIDTH | Processed output word |
| dnBusy | input | 1 | Downstream refuses the offered word |

## Verification
The main corner case is a downstream stall that starts in the same clock as an incoming strobe. A design without the skid capture would drop that word, and one that raised busy only after seeing the stall would let a second word overwrite it. The bench also releases the stall and checks that the skid word comes out first and that busy falls exactly one clock later. A design that served fresh input first would reorder the stream, and one that held busy too long would cost throughput. Long stretches of random busy toggling, plus a data value at the top of the range, test hold-steady behaviour under backpressure and the wrap of the increment.

// File: rtl/bufPipePkg.sv
package bufPipePkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadOutFromSkid;
    logic loadOutFromIn;
    logic loadSkid;
  } pipeCtrlT;
endpackage

// File: rtl/bufPipeProc.sv
module bufPipeProc #(
  parameter int WIDTH = 16,
  parameter int STEP  = 1
) (
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] procOut
);
  localparam logic [WIDTH-1:0] STEPV = WIDTH'(STEP);

  generate
    if (STEP == 0) begin : g_bypass
      assign procOut = rawIn;
    end else begin : g_incr
      assign procOut = rawIn + STEPV;
    end
  endgenerate
endmodule

// File: rtl/bufPipeCtrl.sv
module bufPipeCtrl
  import bufPipePkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     upStb,
  input  logic     dnBusy,
  output pipeCtrlT ctrl,
  output logic     outValid,
  output logic     upBusy
);
  logic outValidQ;
  logic skidValidQ;
  logic upBusyQ;
  logic inAccept;
  logic outFree;
  logic outValidNext;
  logic skidValidNext;

  assign inAccept = upStb & ~upBusyQ;
  assign outFree  = ~outValidQ | ~dnBusy;

  always_comb begin
    ctrl.loadOutFromSkid = outFree & skidValidQ;
    ctrl.loadOutFromIn   = outFree & ~skidValidQ & inAccept;
    ctrl.loadSkid        = ~outFree & inAccept;
  end

  always_comb begin
    if (outFree) outValidNext = skidValidQ | inAccept;
    else         outValidNext = 1'b1;
    if (skidValidQ) skidValidNext = ~outFree;
    else            skidValidNext = ctrl.loadSkid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValidQ  <= 1'b0;
      skidValidQ <= 1'b0;
      upBusyQ    <= 1'b0;
    end else begin
      outValidQ  <= outValidNext;
      skidValidQ <= skidValidNext;
      upBusyQ    <= skidValidNext;
    end
  end

  assign outValid = outValidQ;
  assign upBusy   = upBusyQ;
endmodule

// File: rtl/bufPipeData.sv
module bufPipeData
  import bufPipePkg::*;
#(
  parameter int WIDTH = 16,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  pipeCtrlT         ctrl,
  input  logic [WIDTH-1:0] upData,
  output logic [WIDTH-1:0] dnData
);
  logic [WIDTH-1:0] procWord;
  logic [WIDTH-1:0] skidQ;
  logic [WIDTH-1:0] outQ;

  bufPipeProc #(.WIDTH(WIDTH), .STEP(STEP)) i_proc (
    .rawIn  (upData),
    .procOut(procWord)
  );

  always_ff @(posedge clk) begin
    if (ctrl.loadSkid) skidQ <= procWord;
    if (ctrl.loadOutFromSkid)    outQ <= skidQ;
    else if (ctrl.loadOutFromIn) outQ <= procWord;
  end

  assign dnData = outQ;
endmodule

// File: rtl/bufPipeStage.sv
module bufPipeStage
  import bufPipePkg::*;
#(
  parameter int WIDTH = 16,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upStb,
  input  logic [WIDTH-1:0] upData,
  output logic             upBusy,
  output logic             dnStb,
  output logic [WIDTH-1:0] dnData,
  input  logic             dnBusy
);
  pipeCtrlT ctrl;

  bufPipeCtrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .upStb   (upStb),
    .dnBusy  (dnBusy),
    .ctrl    (ctrl),
    .outValid(dnStb),
    .upBusy  (upBusy)
  );

  bufPipeData #(.WIDTH(WIDTH), .STEP(STEP)) i_data (
    .clk   (clk),
    .ctrl  (ctrl),
    .upData(upData),
    .dnData(dnData)
  );
endmodule

// File: rtl/bufPipeStageChecker.sv
module bufPipeStageChecker #(
  parameter int WIDTH = 16,
  parameter int STEP  = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             upStb,
  input logic [WIDTH-1:0] upData,
  input logic             upBusy,
  input logic             dnStb,
  input logic [WIDTH-1:0] dnData,
  input logic             dnBusy
);
  localparam logic [WIDTH-1:0] STEPV = WIDTH'(STEP);

  // R10
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!dnStb && !upBusy));

  // R8
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (dnStb && dnBusy) |=> (dnStb && $stable(dnData)));

  // R3 and R9: free-flowing word appears processed one clock later
  assert_pass_through_R3: assert property (@(posedge clk) disable iff (rst)
    (upStb && !upBusy && (!dnStb || !dnBusy)) |=>
      (dnStb && dnData == $past(upData) + STEPV));

  // R5
  assert_stall_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (upStb && !upBusy && dnStb && dnBusy) |=> upBusy);

  // R7
  assert_busy_release_R7: assert property (@(posedge clk) disable iff (rst)
    (upBusy && !dnBusy) |=> !upBusy);

  // R4 and R6: a held skid word implies a word on offer, and it is offered next
  assert_skid_drain_R6: assert property (@(posedge clk) disable iff (rst)
    upBusy |-> dnStb);
endmodule

bind bufPipeStage bufPipeStageChecker #(.WIDTH(WIDTH), .STEP(STEP)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .upStb (upStb),
  .upData(upData),
  .upBusy(upBusy),
  .dnStb (dnStb),
  .dnData(dnData),
  .dnBusy(dnBusy)
);

// File: tb/test_bufPipeStage.sv
module test_bufPipeStage;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         upStb = 1'b0;
  logic [W-1:0] upData = '0;
  logic         upBusy;
  logic         dnStb;
  logic [W-1:0] dnData;
  logic         dnBusy = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  int nIn = 0;
  int nOut = 0;
  logic [W-1:0] model[$];   // words inside the stage, oldest first
  logic [W-1:0] nextWord = 16'd5;

  always #5 clk = ~clk;

  bufPipeStage #(.WIDTH(W), .STEP(1)) i_bufPipeStage (
    .clk(clk), .rst(rst), .upStb(upStb), .upData(upData),
    .upBusy(upBusy), .dnStb(dnStb), .dnData(dnData), .dnBusy(dnBusy)
  );

  task automatic check1(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs with the model, then apply inputs and advance the model
  task automatic step(input logic stb, input logic busy);
    @(negedge clk);
    check1("R2 dnStb", W'(dnStb), W'(model.size() > 0));
    check1("R5/R7 upBusy", W'(upBusy), W'(model.size() == 2));
    if (model.size() > 0) check1("R9/R11 dnData", dnData, model[0]);
    upStb  = stb;
    dnBusy = busy;
    upData = nextWord;
    #1;
    if (dnStb && !dnBusy) begin
      void'(model.pop_front());
      nOut++;
    end
    // R1: only a word offered while upBusy is 0 enters the model
    if (upStb && !upBusy) begin
      model.push_back(upData + W'(1));
      nIn++;
    end
    nextWord = nextWord + 16'd3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check1("R10 dnStb", W'(dnStb), '0);
    check1("R10 upBusy", W'(upBusy), '0);
    // R3: free flow, one word per clock
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    // R4, R5: stall begins together with a strobe; R1: offers while busy are ignored
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    // R6, R7: release, skid word first, busy drops one clock after
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    // R8: stall with no new input
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R9: increment wraps at the top of the range
    nextWord = 16'hFFFF;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R11: pseudo-random strobe and busy patterns
    for (int i = 0; i < 400; i++) begin
      int h;
      h = (i * 37 + 11) % 17;
      step(h % 3 != 0, (h % 5) < 2);
    end
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    // R11: every accepted word came out exactly once
    check1("R11 count", W'(nOut), W'(nIn));
    // R10: reset while a word is held
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    upStb = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model.delete();
    check1("R10 dnStb after reset", W'(dnStb), '0);
    check1("R10 upBusy after reset", W'(upBusy), '0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule